// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block keeps the coherence state of every line in a small direct-mapped private cache. Each line holds a 2-bit state (Modified, Exclusive, Shared or Invalid), a tag and one data register. Two request sides drive the state. The local side takes processor reads and writes. It completes hits with no bus traffic, and raises a bus request for misses and for writes to shared lines. The snoop side watches transactions that other caches place on the shared bus. It updates the matching line, answers with a registered shared indication, and supplies dirty data when it holds the line modified.

A local request is held by the requester until `lcl_done` pulses. A bus request is held until `bus_gnt` arrives. With the grant, the bus side returns the combined shared response of the peers and the fill data. When a miss replaces a modified line, the old contents are pushed out on the writeback outputs in the same cycle as `lcl_done`. The line index is the low address bits, and the rest of the address is the tag.

Top module: `mesi_line_ctl`

## Requirements
- R1: After reset every line is Invalid. No snoop then hits, so `snp_shared` and `snp_supply` stay 0, and a local read always goes to the bus.
- R2: A local read miss issues a read request (`bus_op`=01). It completes in Exclusive (`lcl_state`=10) when `bus_shared_in` is 0 at grant, and in Shared (01) when it is 1. The returned data is the fill data.
- R3: A local write miss issues a read-for-ownership request (`bus_op`=10) and completes in Modified (11). The returned `lcl_rdata` of any write is the written data.
- R4: A local write to a Shared line issues an invalidate request (`bus_op`=11) and completes in Modified.
- R5: A local write to an Exclusive line completes in Modified one cycle after acceptance, with no bus request.
- R6: Local read hits in any valid state and local writes to Modified lines complete one cycle after acceptance. They raise no bus request and leave the state unchanged, except that a write always results in Modified.
- R7: A snooped read (`snp_op`=01) that hits an Exclusive or Modified line moves it to Shared. A hit on Modified also asserts `snp_supply` with the line data in `snp_data`.
- R8: A snooped read-for-ownership (10) or invalidate (11) that hits a line moves it to Invalid. If the line was Modified, it first supplies its data on `snp_supply`/`snp_data`.
- R9: `snp_shared` is 1 in the cycle after a snooped read whose tag matches a valid line, and 0 otherwise. A snoop with the same index but a different tag does not disturb the line.
- R10: A snoop and a local request to the same index in the same cycle: the snoop is applied first. The local request is held back that cycle and then evaluated against the post-snoop state. A pending bus request to that index is withdrawn and re-evaluated in the same way.
- R11: A miss that replaces a Modified line pulses `wb_valid` together with `lcl_done`, carrying the old line's address and data. A clean victim produces no writeback.
- R12: The states held by two peer caches for a line never allow two owners. After any transaction, at most one cache holds the line in Modified or Exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl_valid | input | 1 | Local request present, held until lcl_done |
| lcl_write | input | 1 | 1 = write, 0 = read |
| lcl_addr | input | ADDR_W | Local request address |
| lcl_wdata | input | DATA_W | Local write data |
| lcl_done | output | 1 | One-cycle completion pulse |
| lcl_rdata | output | DATA_W | Line data after the access |
| lcl_state | output | 2 | Line state after the access (00 I, 01 S, 10 E, 11 M) |
| bus_req | output | 1 | Bus request pending |
| bus_op | output | 2 | 01 read, 10 read-for-ownership, 11 invalidate |
| bus_addr | output | ADDR_W | Address of the bus request |
| bus_gnt | input | 1 | Request granted and completed this cycle |
| bus_shared_in | input | 1 | A peer holds the line (valid with bus_gnt) |
| bus_fill | input | DATA_W | Fill data (valid with bus_gnt) |
| wb_valid | output | 1 | Writeback of an evicted modified line |
| wb_addr | output | ADDR_W | Writeback address |
| wb_data | output | DATA_W | Writeback data |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped operation, same code as bus_op |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | Registered shared response |
| snp_supply | output | 1 | Registered dirty-data supply flag |
| snp_data | output | DATA_W | Supplied data |

## Verification
A snoop and a local request can both target the same line index in one cycle. The bench provokes this with a cache holding a line in Exclusive. In a single cycle it presents a local write to that line and drives a read-for-ownership snoop on the same address. It then checks that no completion appears in that cycle and that the write comes back as a read-for-ownership bus request instead of a silent upgrade. The rest of the bench runs two instances as peers on a modelled bus, so each state change is judged by the bus operation, the shared and supply responses, and the returned data and state.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_st_t;

    typedef enum logic [1:0] {
        BOP_NONE = 2'b00,
        BOP_RD   = 2'b01,
        BOP_RDX  = 2'b10,
        BOP_INV  = 2'b11
    } bus_op_t;

    typedef struct packed {
        logic     use_bus;
        bus_op_t  op;
        line_st_t nxt;
    } lcl_plan_t;

    // State reached by a line that a peer's bus transaction hits.
    function automatic line_st_t snoop_next(line_st_t cur, bus_op_t op);
        line_st_t r;
        case (op)
            BOP_RD:           r = (cur == ST_I) ? ST_I : ST_S;
            BOP_RDX, BOP_INV: r = ST_I;
            default:          r = cur;
        endcase
        return r;
    endfunction

    // Decide what a local access needs, given the looked-up line.
    function automatic lcl_plan_t plan_local(logic hit, line_st_t cur, logic wr);
        lcl_plan_t p;
        p.use_bus = 1'b0;
        p.op      = BOP_NONE;
        p.nxt     = cur;
        if (!hit) begin
            p.use_bus = 1'b1;
            p.op      = wr ? BOP_RDX : BOP_RD;
            p.nxt     = ST_I;
        end else if (wr) begin
            case (cur)
                ST_S: begin
                    p.use_bus = 1'b1;
                    p.op      = BOP_INV;
                end
                ST_E, ST_M: p.nxt = ST_M;
                default: begin
                    p.use_bus = 1'b1;
                    p.op      = BOP_RDX;
                end
            endcase
        end
        return p;
    endfunction

    // State installed when a bus request completes.
    function automatic line_st_t fill_state(bus_op_t op, logic shared);
        line_st_t r;
        if (op == BOP_RD) r = shared ? ST_S : ST_E;
        else              r = ST_M;
        return r;
    endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2,
    parameter int TAG_W     = 4,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    // lookup port for the local side
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_t          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    // lookup port for the snoop side
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_t          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    // snoop state update (wins on the same index)
    input  logic              sw_en,
    input  logic [IDX_W-1:0]  sw_idx,
    input  line_st_t          sw_st,
    // local line update
    input  logic              lw_en,
    input  logic [IDX_W-1:0]  lw_idx,
    input  line_st_t          lw_st,
    input  logic [TAG_W-1:0]  lw_tag,
    input  logic [DATA_W-1:0] lw_data
);

    line_st_t          st_q   [NUM_LINES];
    logic [TAG_W-1:0]  tag_q  [NUM_LINES];
    logic [DATA_W-1:0] data_q [NUM_LINES];

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (rst) begin
                st_q[i]   <= ST_I;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (sw_en && sw_idx == IDX_W'(i)) begin
                st_q[i] <= sw_st;
            end else if (lw_en && lw_idx == IDX_W'(i)) begin
                st_q[i]   <= lw_st;
                tag_q[i]  <= lw_tag;
                data_q[i] <= lw_data;
            end
        end
    end

    // R10
    store_collide_chk: assert property (@(posedge clk) disable iff (rst)
        !(sw_en && lw_en && sw_idx == lw_idx));

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  bus_op_t           snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  line_st_t          cur_st,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [DATA_W-1:0] cur_data,
    output logic              sw_en,
    output line_st_t          sw_st,
    output logic              shared_q,
    output logic              supply_q,
    output logic [DATA_W-1:0] data_q
);

    logic hit;

    assign hit   = snp_valid && (cur_st != ST_I) && (cur_tag == snp_addr[ADDR_W-1:IDX_W]);
    assign sw_en = hit;
    assign sw_st = snoop_next(cur_st, snp_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            shared_q <= 1'b0;
            supply_q <= 1'b0;
            data_q   <= '0;
        end else begin
            shared_q <= hit && (snp_op == BOP_RD);
            supply_q <= hit && (cur_st == ST_M);
            data_q   <= (hit && cur_st == ST_M) ? cur_data : '0;
        end
    end

    // R9
    snoop_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && snp_op == BOP_RD) |=> shared_q);

    // R7
    dirty_read_supply_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && snp_op == BOP_RD && cur_st == ST_M) |=> (supply_q && !$stable(data_q) || supply_q));

    // R8
    dirty_kill_supply_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && snp_op != BOP_RD && cur_st == ST_M) |=> supply_q);

    // R9
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !snp_valid |=> (!shared_q && !supply_q));

endmodule

// File: rtl/coh_local_fsm.sv
module coh_local_fsm
    import coh_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  line_st_t          cur_st,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [DATA_W-1:0] cur_data,
    input  logic              snoop_clash,
    input  logic              gnt,
    input  logic              shared_in,
    input  logic [DATA_W-1:0] fill,
    output logic              wr_en,
    output line_st_t          wr_st,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output logic              breq,
    output bus_op_t           bop,
    output logic [ADDR_W-1:0] baddr,
    output logic              done_q,
    output logic [DATA_W-1:0] rdata_q,
    output line_st_t          rstate_q,
    output logic              wb_v_q,
    output logic [ADDR_W-1:0] wb_a_q,
    output logic [DATA_W-1:0] wb_d_q
);

    typedef enum logic {PH_IDLE, PH_BUS} phase_t;

    phase_t    ph_q;
    bus_op_t   op_q;
    lcl_plan_t plan;
    logic      hit, accept, finish;
    logic [TAG_W-1:0] req_tag;

    assign req_tag = req_addr[ADDR_W-1:IDX_W];
    assign hit     = (cur_st != ST_I) && (cur_tag == req_tag);
    assign plan    = plan_local(hit, cur_st, req_write);
    assign accept  = (ph_q == PH_IDLE) && req_valid && !done_q && !snoop_clash;
    assign finish  = (ph_q == PH_BUS) && gnt && !snoop_clash;

    assign wr_en   = (accept && !plan.use_bus && req_write) || finish;
    assign wr_st   = finish ? fill_state(op_q, shared_in) : ST_M;
    assign wr_tag  = req_tag;
    assign wr_data = (finish && op_q == BOP_RD) ? fill : req_wdata;

    assign breq  = (ph_q == PH_BUS);
    assign bop   = (ph_q == PH_BUS) ? op_q : BOP_NONE;
    assign baddr = req_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            op_q     <= BOP_NONE;
            done_q   <= 1'b0;
            rdata_q  <= '0;
            rstate_q <= ST_I;
            wb_v_q   <= 1'b0;
            wb_a_q   <= '0;
            wb_d_q   <= '0;
        end else begin
            done_q <= 1'b0;
            wb_v_q <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (accept) begin
                        if (plan.use_bus) begin
                            ph_q <= PH_BUS;
                            op_q <= plan.op;
                        end else begin
                            done_q   <= 1'b1;
                            rdata_q  <= req_write ? req_wdata : cur_data;
                            rstate_q <= plan.nxt;
                        end
                    end
                end
                PH_BUS: begin
                    if (snoop_clash) begin
                        ph_q <= PH_IDLE;
                    end else if (gnt) begin
                        ph_q     <= PH_IDLE;
                        done_q   <= 1'b1;
                        rdata_q  <= wr_data;
                        rstate_q <= wr_st;
                        if (op_q != BOP_INV && cur_st == ST_M) begin
                            wb_v_q <= 1'b1;
                            wb_a_q <= {cur_tag, req_addr[IDX_W-1:0]};
                            wb_d_q <= cur_data;
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R4
    bus_op_named_chk: assert property (@(posedge clk) disable iff (rst)
        breq |-> (bop != BOP_NONE));

    // R5
    silent_upgrade_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && hit && req_write && cur_st == ST_E) |=> (done_q && !breq && rstate_q == ST_M));

    // R6
    owned_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && hit && cur_st == ST_M) |=> (done_q && !breq && rstate_q == ST_M));

    // R10
    clash_holds_chk: assert property (@(posedge clk) disable iff (rst)
        ((ph_q == PH_IDLE) && snoop_clash) |=> (!done_q && !breq));

endmodule

// File: rtl/mesi_line_ctl.sv
module mesi_line_ctl
    import coh_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lcl_valid,
    input  logic              lcl_write,
    input  logic [ADDR_W-1:0] lcl_addr,
    input  logic [DATA_W-1:0] lcl_wdata,
    output logic              lcl_done,
    output logic [DATA_W-1:0] lcl_rdata,
    output logic [1:0]        lcl_state,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_fill,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  l_idx, s_idx;
    line_st_t          a_st, b_st, sw_st, lw_st, rstate;
    logic [TAG_W-1:0]  a_tag, b_tag, lw_tag;
    logic [DATA_W-1:0] a_data, b_data, lw_data;
    logic              sw_en, lw_en, clash;
    bus_op_t           bop;

    assign l_idx = lcl_addr[IDX_W-1:0];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign clash = snp_valid && (s_idx == l_idx);

    coh_line_store #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .a_idx(l_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(s_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .sw_en(sw_en), .sw_idx(s_idx), .sw_st(sw_st),
        .lw_en(lw_en), .lw_idx(l_idx), .lw_st(lw_st), .lw_tag(lw_tag), .lw_data(lw_data)
    );

    coh_snoop_unit #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_snoop (
        .clk(clk), .rst(rst),
        .snp_valid(snp_valid), .snp_op(bus_op_t'(snp_op)), .snp_addr(snp_addr),
        .cur_st(b_st), .cur_tag(b_tag), .cur_data(b_data),
        .sw_en(sw_en), .sw_st(sw_st),
        .shared_q(snp_shared), .supply_q(snp_supply), .data_q(snp_data)
    );

    coh_local_fsm #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_local (
        .clk(clk), .rst(rst),
        .req_valid(lcl_valid), .req_write(lcl_write), .req_addr(lcl_addr), .req_wdata(lcl_wdata),
        .cur_st(a_st), .cur_tag(a_tag), .cur_data(a_data),
        .snoop_clash(clash),
        .gnt(bus_gnt), .shared_in(bus_shared_in), .fill(bus_fill),
        .wr_en(lw_en), .wr_st(lw_st), .wr_tag(lw_tag), .wr_data(lw_data),
        .breq(bus_req), .bop(bop), .baddr(bus_addr),
        .done_q(lcl_done), .rdata_q(lcl_rdata), .rstate_q(rstate),
        .wb_v_q(wb_valid), .wb_a_q(wb_addr), .wb_d_q(wb_data)
    );

    assign bus_op    = bop;
    assign lcl_state = rstate;

endmodule

// File: tb/mesi_line_ctl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctl_tb;

    localparam int AW = 6;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          lcl_valid [2];
    logic          lcl_write [2];
    logic [AW-1:0] lcl_addr  [2];
    logic [DW-1:0] lcl_wdata [2];
    logic          lcl_done  [2];
    logic [DW-1:0] lcl_rdata [2];
    logic [1:0]    lcl_state [2];
    logic          bus_req   [2];
    logic [1:0]    bus_op    [2];
    logic [AW-1:0] bus_addr  [2];
    logic          bus_gnt   [2];
    logic          bus_shared_in [2];
    logic [DW-1:0] bus_fill  [2];
    logic          wb_valid  [2];
    logic [AW-1:0] wb_addr   [2];
    logic [DW-1:0] wb_data   [2];
    logic          snp_valid [2];
    logic [1:0]    snp_op    [2];
    logic [AW-1:0] snp_addr  [2];
    logic          snp_shared [2];
    logic          snp_supply [2];
    logic [DW-1:0] snp_data  [2];

    logic [DW-1:0] mem [64];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    mesi_line_ctl u_dut (
        .clk(clk), .rst(rst),
        .lcl_valid(lcl_valid[0]), .lcl_write(lcl_write[0]), .lcl_addr(lcl_addr[0]), .lcl_wdata(lcl_wdata[0]),
        .lcl_done(lcl_done[0]), .lcl_rdata(lcl_rdata[0]), .lcl_state(lcl_state[0]),
        .bus_req(bus_req[0]), .bus_op(bus_op[0]), .bus_addr(bus_addr[0]),
        .bus_gnt(bus_gnt[0]), .bus_shared_in(bus_shared_in[0]), .bus_fill(bus_fill[0]),
        .wb_valid(wb_valid[0]), .wb_addr(wb_addr[0]), .wb_data(wb_data[0]),
        .snp_valid(snp_valid[0]), .snp_op(snp_op[0]), .snp_addr(snp_addr[0]),
        .snp_shared(snp_shared[0]), .snp_supply(snp_supply[0]), .snp_data(snp_data[0])
    );

    mesi_line_ctl u_peer (
        .clk(clk), .rst(rst),
        .lcl_valid(lcl_valid[1]), .lcl_write(lcl_write[1]), .lcl_addr(lcl_addr[1]), .lcl_wdata(lcl_wdata[1]),
        .lcl_done(lcl_done[1]), .lcl_rdata(lcl_rdata[1]), .lcl_state(lcl_state[1]),
        .bus_req(bus_req[1]), .bus_op(bus_op[1]), .bus_addr(bus_addr[1]),
        .bus_gnt(bus_gnt[1]), .bus_shared_in(bus_shared_in[1]), .bus_fill(bus_fill[1]),
        .wb_valid(wb_valid[1]), .wb_addr(wb_addr[1]), .wb_data(wb_data[1]),
        .snp_valid(snp_valid[1]), .snp_op(snp_op[1]), .snp_addr(snp_addr[1]),
        .snp_shared(snp_shared[1]), .snp_supply(snp_supply[1]), .snp_data(snp_data[1])
    );

    // core, write, addr, wdata, exp bus op, exp state, exp rdata,
    // exp peer shared, exp peer supply, exp writeback, requirement
    typedef struct packed {
        logic          c;
        logic          wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [1:0]    op;
        logic [1:0]    st;
        logic [DW-1:0] rd;
        logic          sh;
        logic          sup;
        logic          wb;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,6'h05,8'h00,2'd1,2'd2,8'h45,1'b0,1'b0,1'b0,4'd2},  // R2 miss, alone -> E
        '{1'b0,1'b0,6'h05,8'h00,2'd0,2'd2,8'h45,1'b0,1'b0,1'b0,4'd6},  // R6 read hit on E
        '{1'b1,1'b0,6'h05,8'h00,2'd1,2'd1,8'h45,1'b1,1'b0,1'b0,4'd9},  // R9 peer E answers shared
        '{1'b0,1'b1,6'h05,8'hA1,2'd3,2'd3,8'hA1,1'b0,1'b0,1'b0,4'd4},  // R4 write on S
        '{1'b0,1'b1,6'h05,8'hA2,2'd0,2'd3,8'hA2,1'b0,1'b0,1'b0,4'd6},  // R6 write on M
        '{1'b1,1'b0,6'h05,8'h00,2'd1,2'd1,8'hA2,1'b1,1'b1,1'b0,4'd7},  // R7 dirty peer supplies
        '{1'b0,1'b0,6'h05,8'h00,2'd0,2'd1,8'hA2,1'b0,1'b0,1'b0,4'd7},  // R7 supplier now S
        '{1'b1,1'b1,6'h05,8'hB3,2'd3,2'd3,8'hB3,1'b0,1'b0,1'b0,4'd4},  // R4 peer write on S
        '{1'b0,1'b1,6'h05,8'hA4,2'd2,2'd3,8'hA4,1'b0,1'b1,1'b0,4'd8},  // R8 RFO kills dirty peer
        '{1'b1,1'b0,6'h05,8'h00,2'd1,2'd1,8'hA4,1'b1,1'b1,1'b0,4'd12}, // R12 peer lost ownership
        '{1'b1,1'b0,6'h0A,8'h00,2'd1,2'd2,8'h4A,1'b0,1'b0,1'b0,4'd2},  // R2
        '{1'b1,1'b1,6'h0A,8'hC5,2'd0,2'd3,8'hC5,1'b0,1'b0,1'b0,4'd5},  // R5 silent E->M
        '{1'b0,1'b0,6'h0A,8'h00,2'd1,2'd1,8'hC5,1'b1,1'b1,1'b0,4'd7},  // R7
        '{1'b0,1'b1,6'h13,8'h77,2'd2,2'd3,8'h77,1'b0,1'b0,1'b0,4'd3},  // R3 write miss
        '{1'b0,1'b0,6'h23,8'h00,2'd1,2'd2,8'h63,1'b0,1'b0,1'b1,4'd11}, // R11 dirty victim
        '{1'b0,1'b0,6'h13,8'h00,2'd1,2'd2,8'h77,1'b0,1'b0,1'b0,4'd11}, // R11 clean victim
        '{1'b1,1'b0,6'h33,8'h00,2'd1,2'd2,8'h73,1'b0,1'b0,1'b0,4'd9},  // R9 tag mismatch
        '{1'b0,1'b0,6'h13,8'h00,2'd0,2'd2,8'h77,1'b0,1'b0,1'b0,4'd9}   // R9 line undisturbed
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start_req(input int c, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        lcl_valid[c] = 1'b1;
        lcl_write[c] = wr;
        lcl_addr[c]  = a;
        lcl_wdata[c] = d;
    endtask

    // Called at a negedge; plays the bus and the peer until completion.
    task automatic serve(input int c, output logic [1:0] op_o, output logic [1:0] st_o,
                         output logic [DW-1:0] rd_o, output logic sh_o, output logic sup_o,
                         output logic wb_o);
        int p = 1 - c;
        int guard = 0;
        bit served = 0;
        bit got = 0;
        op_o = 2'd0; st_o = 2'd0; rd_o = '0; sh_o = 1'b0; sup_o = 1'b0; wb_o = 1'b0;
        @(negedge clk);
        while (!got && guard < 40) begin
            guard++;
            if (lcl_done[c]) begin
                got  = 1;
                rd_o = lcl_rdata[c];
                st_o = lcl_state[c];
                wb_o = wb_valid[c];
                if (wb_valid[c]) mem[wb_addr[c]] = wb_data[c];
                lcl_valid[c] = 1'b0;
            end else if (bus_req[c] && !served) begin
                served = 1;
                op_o = bus_op[c];
                snp_valid[p] = 1'b1;
                snp_op[p]    = bus_op[c];
                snp_addr[p]  = bus_addr[c];
                @(negedge clk);
                snp_valid[p] = 1'b0;
                sh_o  = snp_shared[p];
                sup_o = snp_supply[p];
                if (snp_supply[p]) mem[bus_addr[c]] = snp_data[p];
                bus_gnt[c]       = 1'b1;
                bus_shared_in[c] = snp_shared[p];
                bus_fill[c]      = mem[bus_addr[c]];
                @(negedge clk);
                bus_gnt[c] = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        if (!got) begin
            n_chk++;
            n_bad++;
            $display("FAIL request never completed on core %0d actual=0 expected=1", c);
            lcl_valid[c] = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [1:0] op, st;
        logic [DW-1:0] rd;
        logic sh, sup, wb;

        for (int i = 0; i < 64; i++) mem[i] = 8'(i + 8'h40);
        for (int k = 0; k < 2; k++) begin
            lcl_valid[k] = 0; lcl_write[k] = 0; lcl_addr[k] = '0; lcl_wdata[k] = '0;
            bus_gnt[k] = 0; bus_shared_in[k] = 0; bus_fill[k] = '0;
            snp_valid[k] = 0; snp_op[k] = 2'd0; snp_addr[k] = '0;
        end

        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset
        for (int k = 0; k < 2; k++) begin
            chk("R1 reset lcl_done", lcl_done[k], 0);
            chk("R1 reset bus_req", bus_req[k], 0);
            chk("R1 reset wb_valid", wb_valid[k], 0);
        end
        rst = 1'b0;

        // R1: every index is Invalid, so no snoop read is answered
        for (int idx = 0; idx < 4; idx++) begin
            snp_valid[0] = 1'b1; snp_op[0] = 2'd1; snp_addr[0] = 6'(idx);
            @(negedge clk);
            snp_valid[0] = 1'b0;
            chk($sformatf("R1 empty line %0d shared", idx), snp_shared[0], 0);
            chk($sformatf("R1 empty line %0d supply", idx), snp_supply[0], 0);
        end

        for (int i = 0; i < NV; i++) begin
            start_req(int'(VECS[i].c), VECS[i].wr, VECS[i].a, VECS[i].d);
            serve(int'(VECS[i].c), op, st, rd, sh, sup, wb);
            chk($sformatf("R%0d vec%0d bus_op", VECS[i].req, i), op, VECS[i].op);
            chk($sformatf("R%0d vec%0d state", VECS[i].req, i), st, VECS[i].st);
            chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), rd, VECS[i].rd);
            chk($sformatf("R%0d vec%0d peer shared", VECS[i].req, i), sh, VECS[i].sh);
            chk($sformatf("R%0d vec%0d peer supply", VECS[i].req, i), sup, VECS[i].sup);
            chk($sformatf("R%0d vec%0d writeback", VECS[i].req, i), wb, VECS[i].wb);
        end

        // R10: snoop RFO and a local write hit the same Exclusive line together
        start_req(0, 1'b1, 6'h13, 8'h99);
        snp_valid[0] = 1'b1; snp_op[0] = 2'd2; snp_addr[0] = 6'h13;
        @(negedge clk);
        snp_valid[0] = 1'b0;
        chk("R10 local held back in clash cycle", lcl_done[0], 0);
        chk("R10 no bus request in clash cycle", bus_req[0], 0);
        chk("R8 clean line supplies nothing", snp_supply[0], 0);
        serve(0, op, st, rd, sh, sup, wb);
        chk("R10 write re-evaluated as RFO", op, 2'd2);
        chk("R10 state after RFO", st, 2'd3);
        chk("R10 rdata after RFO", rd, 8'h99);

        // R1: reset in mid-run drops all held lines
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        start_req(0, 1'b0, 6'h05, 8'h00);
        serve(0, op, st, rd, sh, sup, wb);
        chk("R1 post-reset read goes to bus", op, 2'd1);
        chk("R1 post-reset peer not shared", sh, 0);
        chk("R1 post-reset state E", st, 2'd2);
        chk("R1 post-reset data from memory", rd, 8'hA4);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule